// File: doc/BRIEF.md
# Message-Based Interrupt Assertion Register

This block is the receiving end of message-signalled interrupts in an I/O interrupt controller. Bus masters post a write to a fixed register of the controller. The low byte of that write names an interrupt line, and the block turns each valid write into one edge-style assertion pulse on that line. The pulse goes to the controller's redirection logic. Each line driven this way belongs to this scheme alone. It carries only edges and must never be ORed with shared PCI lines, serial-IRQ sources or level-triggered internal sources.

The slave port is a simple register bus: a byte address, 32-bit write data, byte enables, a write strobe and a combinational read-data output. The register map has two entries. The assertion register sits at offset 0x20. A read-only version word at offset 0x00 carries a capability flag that tells software message delivery is available.

Writes that name a legacy line reserved by the platform (0, 2, 8, 13) are dropped without effect. So are writes that name a line the controller does not implement. Pulses on one line are kept apart by at least one low cycle. Writes that arrive while a pulse is still high are held in a small per-line backlog and replayed, so no accepted write is lost.

Top module: `msgirq_assert`

## Requirements
- R1: A write with bus_addr[7:2] = 0x08 (byte offset 0x20), bus_be[0] = 1 and bus_wdata[7:0] = n, where n is implemented and not reserved, drives irq_pulse[n] high for exactly one cycle. On an idle line this happens in the cycle right after the write edge. bus_wdata[31:8] does not matter.
- R2: Writes naming line 0, 2, 8 or 13 produce no pulse on any line.
- R3: Writes naming a line number of NUM_LINES or more (default 24) produce no pulse. This covers every value up to 0xFF.
- R4: Writes to the assertion register with bus_be[0] = 0 produce no pulse.
- R5: Writes to any other offset, including 0x00 and 0x24, produce no pulse.
- R6: Every accepted write yields its own pulse. A high cycle on a line is always followed by a low cycle. Writes arriving while a line's pulse is high are queued, up to 2**CNT_W-1 pending (3 by default), and replayed in later cycles.
- R7: Reading offset 0x20 returns 0.
- R8: Reading offset 0x00 returns the version word, with the following fields:
  - bits [7:0] = VERSION (default 0x20);
  - bit 15 = 1, the capability flag for message delivery;
  - bits [23:16] = NUM_LINES-1;
  - all other bits 0.
  Reads of unmapped offsets return 0.
- R9: While rst_n is low, and after reset, every irq_pulse bit is 0 and no backlog is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the controller window |
| bus_wdata | input | 32 | Write data; low byte is the line number |
| bus_be | input | 4 | Byte enables for the write |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | NUM_LINES | One-cycle assertion pulse per line |

## Verification
A decode fault shows up within one cycle of the write. It appears either as a pulse on a reserved, out-of-range or wrong line, or as a missing pulse that leaves an expected item behind in the scoreboard. A corrupted backlog counter only shows later. It appears as a surplus or missing pulse some cycles after a burst of writes to one line, which is why the bench drains for a dozen cycles after each burst and checks that the scoreboard is empty. A pulse that stays high two cycles, or that merges with the next one, is visible at once at the line's output.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
   localparam int unsigned VER_OFS    = 'h00;
   localparam int unsigned ASSERT_OFS = 'h20;
   localparam int unsigned CAP_BIT    = 15;

   function automatic logic is_legacy_rsvd(input logic [7:0] n);
      return (n == 8'd0) || (n == 8'd2) || (n == 8'd8) || (n == 8'd13);
   endfunction
endpackage

// File: rtl/msgirq_decode.sv
module msgirq_decode
   import msgirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_LINES = 24
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   input  logic [3:0]           be,
   input  logic                 wr,
   output logic [NUM_LINES-1:0] line_sel
);
   localparam logic [ADDR_W-1:0] A_ASSERT = ADDR_W'(ASSERT_OFS);

   logic [7:0] num;
   logic       hit, in_range, accept;
   logic       unused_bits;

   assign num         = wdata[7:0];
   assign hit         = (addr[ADDR_W-1:2] == A_ASSERT[ADDR_W-1:2]);
   assign in_range    = (32'(num) < NUM_LINES);
   assign accept      = wr && hit && be[0] && in_range && !is_legacy_rsvd(num);
   assign unused_bits = ^{wdata[31:8], be[3:1], addr[1:0]};

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
      assign line_sel[i] = accept && (num == 8'(i));
   end
endmodule

// File: rtl/msgirq_line.sv
module msgirq_line #(
   parameter int unsigned CNT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pulse
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             pulse_q, fire;

   assign fire  = !pulse_q && (req || (cnt_q != '0));
   assign pulse = pulse_q;

   always_comb begin
      cnt_d = cnt_q;
      if (req && !fire) begin
         if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      end else if (!req && fire) begin
         cnt_d = cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         pulse_q <= fire;
      end
   end

   // R6
   pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R1
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> ($past(req) || ($past(cnt_q) != '0)));

   // R9
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!pulse_q && (cnt_q == '0)));
endmodule

// File: rtl/msgirq_readmux.sv
module msgirq_readmux
   import msgirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_LINES = 24,
   parameter logic [7:0]  VERSION   = 8'h20
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [31:0]       rdata
);
   localparam logic [ADDR_W-1:0] A_VER = ADDR_W'(VER_OFS);
   localparam logic [7:0]        MAXE  = 8'(NUM_LINES - 1);

   logic unused_bits;
   assign unused_bits = ^addr[1:0];

   always_comb begin
      rdata = '0;
      if (addr[ADDR_W-1:2] == A_VER[ADDR_W-1:2])
         rdata = {8'h00, MAXE, 1'b1, 7'h00, VERSION};
   end
endmodule

// File: rtl/msgirq_assert.sv
module msgirq_assert
   import msgirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_LINES = 24,
   parameter int unsigned CNT_W     = 2,
   parameter logic [7:0]  VERSION   = 8'h20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [3:0]           bus_be,
   input  logic                 bus_wr,
   output logic [31:0]          bus_rdata,
   output logic [NUM_LINES-1:0] irq_pulse
);
   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("NUM_LINES must lie in 2..256");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] A_ASSERT = ADDR_W'(ASSERT_OFS);
   localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(VER_OFS);

   logic [NUM_LINES-1:0] line_sel;

   msgirq_decode #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_dec (
      .addr(bus_addr), .wdata(bus_wdata), .be(bus_be), .wr(bus_wr),
      .line_sel(line_sel)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      msgirq_line #(.CNT_W(CNT_W)) u_line (
         .clk(clk), .rst_n(rst_n), .req(line_sel[i]), .pulse(irq_pulse[i])
      );
      if (is_legacy_rsvd(8'(i))) begin : g_rsvd
         // R2
         rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_pulse[i]);
      end
   end

   msgirq_readmux #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .VERSION(VERSION)) u_rd (
      .addr(bus_addr), .rdata(bus_rdata)
   );

   // R7
   rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[ADDR_W-1:2] == A_ASSERT[ADDR_W-1:2]) |-> (bus_rdata == '0));

   // R8
   cap_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[ADDR_W-1:2] == A_VER[ADDR_W-1:2]) |-> bus_rdata[CAP_BIT]);
endmodule

// File: tb/sim_msgirq_assert.sv
module sim_msgirq_assert;
   localparam int CLK_PERIOD = 10;
   localparam int NUM = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_rdata;
   logic [NUM-1:0] irq_pulse;

   int    n_chk = 0;
   int    n_fail = 0;
   int    exp_q[$];
   string cur_req = "R9";
   logic  done = 1'b0;
   logic [NUM-1:0] prev_p = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msgirq_assert u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
   );

   function automatic bit will_accept(logic [7:0] a, logic [31:0] d, logic [3:0] be);
      logic [7:0] n;
      n = d[7:0];
      return (a[7:2] == 6'h08) && be[0] && (int'(n) < NUM) &&
             !(n == 8'd0 || n == 8'd2 || n == 8'd8 || n == 8'd13);
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                            input logic [3:0] be, input string tag);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      cur_req = tag;
      if (will_accept(a, d, be)) exp_q.push_back(int'(d[7:0]));
      @(posedge clk); #1;
   endtask

   task automatic bus_idle();
      bus_wr = 1'b0;
   endtask

   task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #2;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic drain_chk(input string tag);
      repeat (12) @(posedge clk);
      #1;
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL %s pending pulses: got %0d expected 0", tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   // monitor: match each observed pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < NUM; i++) begin
            if (irq_pulse[i]) begin
               int idx;
               idx = -1;
               if (prev_p[i]) begin
                  n_chk++;
                  n_fail++;
                  $display("FAIL R6 line %0d high two cycles: got 1 expected 0", i);
               end
               foreach (exp_q[j]) if (idx < 0 && exp_q[j] == i) idx = j;
               n_chk++;
               if (idx < 0) begin
                  n_fail++;
                  $display("FAIL %s unexpected pulse line %0d: got 1 expected 0", cur_req, i);
               end else begin
                  exp_q.delete(idx);
               end
            end
         end
         prev_p = irq_pulse;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      n_chk++;
      if (irq_pulse !== '0) begin
         n_fail++;
         $display("FAIL R9 pulses in reset: got 0x%06h expected 0x000000", irq_pulse);
      end
      rst_n = 1'b1;
      @(posedge clk); #1;

      read_chk(8'h20, 32'h0, "R7");
      read_chk(8'h00, {8'h00, 8'(NUM-1), 1'b1, 7'h00, 8'h20}, "R8");
      read_chk(8'h10, 32'h0, "R8");
      read_chk(8'h24, 32'h0, "R8");

      // R1 single writes, upper data bits set
      bus_write(8'h20, 32'hDEAD_0001, 4'b0001, "R1"); bus_idle(); @(posedge clk); #1;
      bus_write(8'h20, 32'h0000_0003, 4'b1111, "R1"); bus_idle(); @(posedge clk); #1;
      bus_write(8'h23, 32'h1234_5617, 4'b0001, "R1"); bus_idle();
      drain_chk("R1");

      // R2 reserved lines
      bus_write(8'h20, 32'h0, 4'b1111, "R2");
      bus_write(8'h20, 32'h2, 4'b1111, "R2");
      bus_write(8'h20, 32'h8, 4'b1111, "R2");
      bus_write(8'h20, 32'hD, 4'b1111, "R2"); bus_idle();
      drain_chk("R2");

      // R3 out of range
      bus_write(8'h20, 32'h18, 4'b1111, "R3");
      bus_write(8'h20, 32'hFF, 4'b1111, "R3");
      bus_write(8'h20, 32'h0000_0104, 4'b1110, "R4"); bus_idle();
      drain_chk("R3");

      // R4 low byte not enabled
      bus_write(8'h20, 32'h5, 4'b1110, "R4");
      bus_write(8'h20, 32'h5, 4'b0000, "R4"); bus_idle();
      drain_chk("R4");

      // R5 other offsets
      bus_write(8'h00, 32'h5, 4'b1111, "R5");
      bus_write(8'h24, 32'h5, 4'b1111, "R5");
      bus_write(8'h1C, 32'h5, 4'b1111, "R5"); bus_idle();
      drain_chk("R5");

      // R6 back-to-back on one line, then mixed lines
      bus_write(8'h20, 32'h5, 4'b0001, "R6");
      bus_write(8'h20, 32'h5, 4'b0001, "R6");
      bus_write(8'h20, 32'h5, 4'b0001, "R6");
      bus_write(8'h20, 32'h5, 4'b0001, "R6"); bus_idle();
      drain_chk("R6");
      bus_write(8'h20, 32'h9, 4'b0001, "R6");
      bus_write(8'h20, 32'h9, 4'b0001, "R6");
      bus_write(8'h20, 32'h10, 4'b0001, "R6");
      bus_write(8'h20, 32'h9, 4'b0001, "R6"); bus_idle();
      drain_chk("R6");

      // R1 highest implemented line after ignored traffic
      bus_write(8'h20, 32'h2, 4'b1111, "R2");
      bus_write(8'h20, 32'h17, 4'b0001, "R1"); bus_idle();
      drain_chk("R1");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule